// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This core executes one instruction per clock. Each cycle it fetches the word at the program counter, decodes it, reads two registers and computes a result in the ALU. At the same clock edge it writes a register or the data memory and moves the program counter on. It handles five register-register operations: add, subtract, AND, OR and signed set-less-than. It also handles word load, word store, branch-if-equal and an absolute jump.

The instruction memory and the data memory sit outside the core, on two separate ports. Both are word arrays indexed by byte address bits [..:2], and both reads are combinational. The data memory is written on the rising edge while the write strobe is high. The core holds the program counter and a register file with 32 entries, two read ports and one write port. It also holds the sign extender, the ALU, an incrementer, a separate branch-target adder and the control decoder.

Top module: `scpu_top`

## Requirements
- R1: While `rstN` is low, `instrAddr` equals `RESET_PC` (default 0) and all registers are cleared, so a register never written reads as 0.
- R2: Fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0]. Opcode 0 with shamt 0 and funct 32/34/36/37 writes rs+rt, rs−rt, rs&rt or rs|rt to rd, and PC advances by 4.
- R3: Opcode 0 with funct 42 writes 1 to rd when rs is less than rt as signed 32-bit values, else 0.
- R4: Opcode 35 (load) writes the data word at byte address rs + sign-extended [15:0] into rt, and PC advances by 4.
- R5: Opcode 43 (store) raises `dataWrEn` with `dataAddr` = rs + sign-extended [15:0] and `dataWrData` = rt. No other opcode raises `dataWrEn`.
- R6: Opcode 4 sets the next PC to PC+4+(sign-extended [15:0] << 2) when rs equals rt, else PC+4. It writes nothing. Both forward and backward offsets work.
- R7: Opcode 2 sets the next PC to {PC+4 [31:28], [25:0], 2'b00} and writes nothing.
- R8: Register 0 reads as zero. A write to it has no effect.
- R9: An opcode other than 0, 2, 4, 35 and 43 is a no-op: no register write, no memory write, PC+4. The same holds for opcode 0 with a nonzero shamt or a funct outside 32/34/36/37/42.
- R10: A register written by one instruction is seen by the next instruction's read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| instrAddr | output | 32 | Byte address of the instruction being executed (PC) |
| instrData | input | 32 | Instruction word at `instrAddr` |
| dataAddr | output | 32 | Byte address for data access (ALU result) |
| dataWrData | output | 32 | Store data (second register operand) |
| dataWrEn | output | 1 | Data memory write strobe, taken at the rising edge |
| dataRdEn | output | 1 | High during a load |
| dataRdData | input | 32 | Data word at `dataAddr` |

## Verification
The bench builds the core with `RESET_PC` = 0 and `NUM_REGS` = 32. Zero is the only reset address for which the bench's absolute jump targets and its memory image line up. A reference model runs the program and gives the expected PC and store for every cycle. A store placed after each computation makes register results visible at the ports. The program reaches a branch taken forward, a branch not taken and a backward loop that counts down through zero. It also covers a negative load/store offset, a signed compare across the sign bit, writes to register 0, and no-op encodings that would otherwise decode as a store or an add.

// File: rtl/scpu_pkg.sv
package scpu_pkg;
  localparam int XLEN  = 32;
  localparam int OP_W  = 6;
  localparam int RIDX_W = 5;
  localparam int FNF_W = 11; // shamt + funct

  localparam logic [OP_W-1:0] OP_RTYPE = 6'd0;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'd2;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'd4;
  localparam logic [OP_W-1:0] OP_LW    = 6'd35;
  localparam logic [OP_W-1:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } aluCtl_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aluOp_e;

  typedef struct packed {
    logic    regDst;
    logic    aluSrc;
    logic    memToReg;
    logic    regWrite;
    logic    memRead;
    logic    memWrite;
    logic    branch;
    logic    jump;
    aluCtl_e aluCtl;
  } ctrl_t;
endpackage

// File: rtl/scpu_ctrl.sv
module scpu_ctrl
  import scpu_pkg::*;
(
  input  logic [OP_W-1:0]  opcode,
  input  logic [FNF_W-1:0] fnField,
  output ctrl_t            ctl
);
  logic    fnOk;
  aluCtl_e fnAlu;
  aluOp_e  aluOp;

  // function-field decode: shamt must be zero and funct one of five
  always_comb begin
    fnOk  = (fnField[10:6] == 5'd0);
    fnAlu = ALU_ADD;
    unique case (fnField[5:0])
      FN_ADD:  fnAlu = ALU_ADD;
      FN_SUB:  fnAlu = ALU_SUB;
      FN_AND:  fnAlu = ALU_AND;
      FN_OR:   fnAlu = ALU_OR;
      FN_SLT:  fnAlu = ALU_SLT;
      default: fnOk  = 1'b0;
    endcase
  end

  always_comb begin
    ctl   = '0;
    aluOp = AOP_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctl.regDst   = 1'b1;
        ctl.regWrite = fnOk;
        aluOp        = AOP_FUNCT;
      end
      OP_LW: begin
        ctl.aluSrc   = 1'b1;
        ctl.memToReg = 1'b1;
        ctl.regWrite = 1'b1;
        ctl.memRead  = 1'b1;
      end
      OP_SW: begin
        ctl.aluSrc   = 1'b1;
        ctl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        aluOp      = AOP_SUB;
      end
      OP_JUMP: ctl.jump = 1'b1;
      default: ;
    endcase
    case (aluOp)
      AOP_SUB:   ctl.aluCtl = ALU_SUB;
      AOP_FUNCT: ctl.aluCtl = fnAlu;
      default:   ctl.aluCtl = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile
  import scpu_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AW-1:0]   raddrA,
  input  logic [AW-1:0]   raddrB,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdataA,
  output logic [XLEN-1:0] rdataB
);
  logic [XLEN-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[0] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                         regs[g] <= '0;
        else if (we && waddr == AW'(g))    regs[g] <= wdata;
      end
    end
  end

  assign rdataA = regs[raddrA];
  assign rdataB = regs[raddrB];
endmodule

// File: rtl/scpu_dpath.sv
module scpu_dpath
  import scpu_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter int NUM_REGS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctl,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] dataRdData,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] dataAddr,
  output logic [XLEN-1:0] dataWrData,
  output logic            dataWrEn,
  output logic            dataRdEn
);
  logic [XLEN-1:0] pcPlus4, brTarget, jTarget, pcNext;
  logic [XLEN-1:0] immExt, opA, opB, rdB, aluRes, wbData;
  logic [RIDX_W-1:0] wAddr;
  logic zero;

  assign immExt   = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign pcPlus4  = pc + XLEN'(4);
  assign brTarget = pcPlus4 + (immExt << 2);
  assign jTarget  = {pcPlus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};

  always_comb begin
    if (ctl.jump)                  pcNext = jTarget;
    else if (ctl.branch && zero)   pcNext = brTarget;
    else                           pcNext = pcPlus4;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pc <= RESET_PC;
    else       pc <= pcNext;
  end

  assign wAddr  = ctl.regDst ? instr[15:11] : instr[20:16];
  assign wbData = ctl.memToReg ? dataRdData : aluRes;

  scpu_regfile #(.NUM_REGS(NUM_REGS)) i_regs (
    .clk    (clk),
    .rstN   (rstN),
    .raddrA (instr[25:21]),
    .raddrB (instr[20:16]),
    .we     (ctl.regWrite),
    .waddr  (wAddr),
    .wdata  (wbData),
    .rdataA (opA),
    .rdataB (rdB)
  );

  assign opB = ctl.aluSrc ? immExt : rdB;

  always_comb begin
    case (ctl.aluCtl)
      ALU_AND: aluRes = opA & opB;
      ALU_OR:  aluRes = opA | opB;
      ALU_SUB: aluRes = opA - opB;
      ALU_SLT: aluRes = ($signed(opA) < $signed(opB)) ? XLEN'(1) : '0;
      default: aluRes = opA + opB;
    endcase
  end
  assign zero = (aluRes == '0);

  assign dataAddr   = aluRes;
  assign dataWrData = rdB;
  assign dataWrEn   = ctl.memWrite;
  assign dataRdEn   = ctl.memRead;
endmodule

// File: rtl/scpu_top.sv
module scpu_top
  import scpu_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter int NUM_REGS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  output logic [31:0] instrAddr,
  input  logic [31:0] instrData,
  output logic [31:0] dataAddr,
  output logic [31:0] dataWrData,
  output logic        dataWrEn,
  output logic        dataRdEn,
  input  logic [31:0] dataRdData
);
  ctrl_t ctl;

  scpu_ctrl i_ctrl (
    .opcode  (instrData[31:26]),
    .fnField (instrData[10:0]),
    .ctl     (ctl)
  );

  scpu_dpath #(.RESET_PC(RESET_PC), .NUM_REGS(NUM_REGS)) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .instr      (instrData),
    .dataRdData (dataRdData),
    .pc         (instrAddr),
    .dataAddr   (dataAddr),
    .dataWrData (dataWrData),
    .dataWrEn   (dataWrEn),
    .dataRdEn   (dataRdEn)
  );
endmodule

// File: rtl/scpu_chk.sv
module scpu_chk #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] instrAddr,
  input logic [31:0] instrData,
  input logic        dataWrEn
);
  logic [5:0]  op;
  logic [31:0] seqPc, jTgt, brTgt;
  logic        knownOp;

  assign op      = instrData[31:26];
  assign seqPc   = instrAddr + 32'd4;
  assign jTgt    = {seqPc[31:28], instrData[25:0], 2'b00};
  assign brTgt   = seqPc + {{14{instrData[15]}}, instrData[15:0], 2'b00};
  assign knownOp = (op == 6'd0) || (op == 6'd2) || (op == 6'd4) ||
                   (op == 6'd35) || (op == 6'd43);

  p_reset_pc_r1: assert property (@(posedge clk)
    !rstN |=> instrAddr == RESET_PC);

  p_seq_pc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (op == 6'd0 || op == 6'd35 || op == 6'd43) |=> instrAddr == $past(seqPc));

  p_store_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    dataWrEn |-> op == 6'd43);

  p_branch_dest_r6: assert property (@(posedge clk) disable iff (!rstN)
    op == 6'd4 |=> (instrAddr == $past(seqPc)) || (instrAddr == $past(brTgt)));

  p_jump_dest_r7: assert property (@(posedge clk) disable iff (!rstN)
    op == 6'd2 |=> instrAddr == $past(jTgt));

  p_unknown_nowrite_r9: assert property (@(posedge clk) disable iff (!rstN)
    !knownOp |-> !dataWrEn);

  p_unknown_seq_r9: assert property (@(posedge clk) disable iff (!rstN)
    !knownOp |=> instrAddr == $past(seqPc));
endmodule

bind scpu_top scpu_chk #(.RESET_PC(RESET_PC)) i_scpu_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instrAddr (instrAddr),
  .instrData (instrData),
  .dataWrEn  (dataWrEn)
);

// File: tb/test_scpu_top.sv
module test_scpu_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instrAddr, instrData, dataAddr, dataWrData, dataRdData;
  logic        dataWrEn, dataRdEn;

  always #5 clk = ~clk;

  scpu_top i_scpu_top (
    .clk        (clk),
    .rstN       (rstN),
    .instrAddr  (instrAddr),
    .instrData  (instrData),
    .dataAddr   (dataAddr),
    .dataWrData (dataWrData),
    .dataWrEn   (dataWrEn),
    .dataRdEn   (dataRdEn),
    .dataRdData (dataRdData)
  );

  // ---------------- encoders and program ----------------
  function automatic logic [31:0] encR(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] encI(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] encJ(int tgt);
    return {6'd2, 26'(tgt)};
  endfunction

  function automatic logic [31:0] progWord(int idx);
    case (idx)
      0:  return encI(35, 0, 1, 4);
      1:  return encI(35, 0, 2, 8);
      2:  return encR(1, 2, 3, 0, 32);
      3:  return encI(43, 0, 3, 64);
      4:  return encR(1, 2, 4, 0, 34);
      5:  return encI(43, 0, 4, 68);
      6:  return encR(1, 2, 5, 0, 36);
      7:  return encI(43, 0, 5, 72);
      8:  return encR(1, 2, 6, 0, 37);
      9:  return encI(43, 0, 6, 76);
      10: return encR(1, 2, 7, 0, 42);
      11: return encI(43, 0, 7, 80);
      12: return encR(2, 1, 8, 0, 42);
      13: return encI(43, 0, 8, 84);
      14: return encR(1, 2, 0, 0, 32);
      15: return encI(43, 0, 0, 88);
      16: return {6'd63, 5'd0, 5'd1, 16'd92};
      17: return encI(35, 0, 12, 12);
      18: return encI(35, 12, 10, -8);
      19: return encI(43, 12, 10, -4);
      20: return encI(35, 0, 14, 20);
      21: return encI(35, 0, 13, 24);
      22: return encI(4, 1, 1, 2);
      23: return encI(43, 0, 1, 100);
      24: return encI(43, 0, 2, 104);
      25: return encI(4, 1, 2, 5);
      26: return encR(13, 14, 13, 0, 34);
      27: return encI(43, 0, 13, 96);
      28: return encI(4, 13, 0, 1);
      29: return encI(4, 0, 0, -4);
      30: return encJ(33);
      31: return encI(43, 0, 1, 108);
      32: return encI(43, 0, 2, 112);
      33: return encI(43, 0, 12, 116);
      34: return encR(1, 2, 11, 0, 39);
      35: return encR(1, 2, 15, 3, 32);
      36: return encI(43, 0, 11, 120);
      37: return encI(43, 0, 15, 124);
      38: return encI(43, 0, 9, 92);
      39: return encJ(39);
      default: return {6'd63, 26'd0};
    endcase
  endfunction

  function automatic logic [31:0] dInit(int i);
    case (i)
      1:  return 32'h8000_0010;
      2:  return 32'h0000_7F03;
      3:  return 32'h0000_0040;
      5:  return 32'h0000_0001;
      6:  return 32'h0000_0003;
      14: return 32'hCAFE_F00D;
      default: return (32'(i) * 32'h0101_0101) ^ 32'h5A5A_0000;
    endcase
  endfunction

  // ---------------- memory models ----------------
  logic [31:0] dmem [64];
  initial for (int i = 0; i < 64; i++) dmem[i] = dInit(i);

  assign instrData  = (instrAddr[31:8] == 24'd0) ? progWord(int'(instrAddr[7:2]))
                                                 : {6'd63, 26'd0};
  assign dataRdData = dmem[dataAddr[7:2]];

  always @(posedge clk) if (rstN && dataWrEn) dmem[dataAddr[7:2]] <= dataWrData;

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [31:0] pc;
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: reference model of the instruction set, one item per cycle
  task automatic buildExpected(input int steps);
    logic [31:0] r [32];
    logic [31:0] m [64];
    bit          written [32];
    logic [31:0] pc = 32'h0;
    int          prevDest = -1;
    for (int i = 0; i < 32; i++) begin r[i] = '0; written[i] = 0; end
    for (int i = 0; i < 64; i++) m[i] = dInit(i);
    for (int s = 0; s < steps; s++) begin
      exp_t e;
      logic [31:0] ins, imm, val, nxt, addr;
      int op, rs, rt, rd, dest;
      ins  = (pc[31:8] == 24'd0) ? progWord(int'(pc[7:2])) : {6'd63, 26'd0};
      op   = int'(ins[31:26]);
      rs   = int'(ins[25:21]);
      rt   = int'(ins[20:16]);
      rd   = int'(ins[15:11]);
      imm  = {{16{ins[15]}}, ins[15:0]};
      nxt  = pc + 32'd4;
      dest = -1;
      val  = '0;
      e.pc = pc; e.we = 1'b0; e.addr = '0; e.data = '0; e.tag = "R9";
      case (op)
        0: begin
          if (ins[10:6] == 5'd0 && (ins[5:0] == 6'd32 || ins[5:0] == 6'd34 ||
              ins[5:0] == 6'd36 || ins[5:0] == 6'd37 || ins[5:0] == 6'd42)) begin
            case (ins[5:0])
              6'd32: val = r[rs] + r[rt];
              6'd34: val = r[rs] - r[rt];
              6'd36: val = r[rs] & r[rt];
              6'd37: val = r[rs] | r[rt];
              default: val = ($signed(r[rs]) < $signed(r[rt])) ? 32'd1 : 32'd0;
            endcase
            dest  = rd;
            e.tag = (ins[5:0] == 6'd42) ? "R3" : "R2";
          end
        end
        35: begin
          addr = r[rs] + imm;
          val = m[addr[7:2]];
          dest = rt;
          e.tag = "R4";
        end
        43: begin
          addr = r[rs] + imm;
          e.we = 1'b1; e.addr = addr; e.data = r[rt];
          m[addr[7:2]] = r[rt];
          if (rt == 0)              e.tag = "R8";
          else if (!written[rt])    e.tag = "R1";
          else if (rt == prevDest)  e.tag = "R10";
          else                      e.tag = "R5";
        end
        4: begin
          if (r[rs] == r[rt]) nxt = pc + 32'd4 + (imm << 2);
          e.tag = "R6";
        end
        2: begin
          nxt = {pc[31:28] + 4'd0, ins[25:0], 2'b00};
          nxt[31:28] = (pc + 32'd4) >> 28;
          e.tag = "R7";
        end
        default: ;
      endcase
      if (dest == 0) e.tag = "R8";
      else if (dest > 0) begin r[dest] = val; written[dest] = 1; end
      prevDest = dest;
      expQ.push_back(e);
      pc = nxt;
    end
  endtask

  // monitor: compares one expected item per cycle away from the clock edge
  initial begin
    buildExpected(80);
    repeat (3) begin
      @(negedge clk);
      check(instrAddr == 32'h0, "R1", "PC during reset", instrAddr, 32'h0);
    end
    @(posedge clk);
    #1 rstN = 1'b1;
    while (expQ.size() > 0) begin
      exp_t e;
      @(negedge clk);
      e = expQ.pop_front();
      check(instrAddr == e.pc, e.tag, "PC", instrAddr, e.pc);
      check(dataWrEn == e.we, e.tag, "store strobe", 32'(dataWrEn), 32'(e.we));
      if (e.we && dataWrEn) begin
        check(dataAddr == e.addr, e.tag, "store address", dataAddr, e.addr);
        check(dataWrData == e.data, e.tag, "store data", dataWrData, e.data);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule